// File: doc/BRIEF.md
# Multi-Channel Match Timer

A register-mapped timer block holding several independent up-counters. Each counter advances by one on every clock cycle where the tick input chosen by its select field is high and its run bit is set. A counter either runs freely and wraps, or runs periodically and restarts from zero after its first comparator matches. Every counter has several match comparators. Each comparator sets a sticky status bit that software clears by writing a one. Each counter drives one interrupt line, which is the OR of its status bits masked by an enable mask.

Software never reads a live counter directly. It writes a request to the capture register of that counter. A fixed two clock edges later, the counter value is latched into that register, which then reads back as the latched value. The bus is a single-cycle write strobe with an address and a combinational read-data path. All addresses are word addresses.

Top module: `mtimer_top`

## Requirements
- R1: After reset, every counter, status, interrupt-enable, match, capture, run, mode and tick-select field is zero and every interrupt line is low.
- R2: Address 0x00 bit n is the run bit of counter n. While the bit is 0 the counter holds its value. Setting it again resumes counting from the held value.
- R3: Address 0x02 bits [2n+1:2n] select which tick input advances counter n. A running counter increments by one at each clock edge where the selected tick input is high, and it ignores the other tick inputs.
- R4: In free-running mode (address 0x01 bit n = 0), the counter wraps from its all-ones value to zero.
- R5: In periodic mode (address 0x01 bit n = 1), a tick that arrives while the count equals match 0 loads zero instead of incrementing. A match value of N−1 therefore gives a period of N ticks.
- R6: Counter n occupies addresses 0x10+8n to 0x17+8n. Status is at offset 0, interrupt enable at offset 1, capture at offset 2, and match k at offset 4+k. Status bit k is set in any cycle where counter n is running and its count equals match k. The bit stays set until it is cleared.
- R7: Writing status with bit k = 1 clears status bit k. Writing 0 to a bit leaves it unchanged. When a set and a clear of the same bit coincide, the bit stays set.
- R8: Interrupt line n is high exactly when some status bit k of counter n and its enable bit k (bit k at offset 1) are both 1.
- R9: A write with data bit 0 = 1 to the capture offset latches the count at the second clock edge after the write edge. Until then, reads of that offset return the previous capture.
- R10: Reads of unmapped addresses return zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_addr_i | input | 8 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| tick_i | input | NUM_TICK (4) | Tick-enable sources |
| irq_o | output | NUM_TIMERS (3) | One interrupt line per counter |

## Verification
The bench builds the block with CNT_W = 8 and keeps the other parameters at their defaults: three counters, three comparators and four tick sources. The narrow counter brings a full wrap within reach in 256 ticks. Random match values in the same 8-bit range also make comparator hits frequent, so set-and-clear collisions and periodic reloads occur often in the random phase. Four tick sources let every value of each 2-bit select field be exercised, including selects that must ignore an active tick.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;
    localparam int unsigned BUS_W     = 32;
    localparam int unsigned ADDR_W    = 8;
    localparam int unsigned OFS_W     = 3;
    localparam int unsigned CH_STRIDE = 1 << OFS_W;

    localparam logic [ADDR_W-1:0] A_RUN     = 8'h00;
    localparam logic [ADDR_W-1:0] A_MODE    = 8'h01;
    localparam logic [ADDR_W-1:0] A_TSEL    = 8'h02;
    localparam logic [ADDR_W-1:0] A_CH_BASE = 8'h10;

    typedef enum logic [OFS_W-1:0] {
        OFS_STAT  = 3'd0,
        OFS_IEN   = 3'd1,
        OFS_CAP   = 3'd2,
        OFS_MATCH = 3'd4
    } ch_ofs_e;

    function automatic logic [ADDR_W-1:0] ch_addr(int unsigned ch, int unsigned ofs);
        return A_CH_BASE + ADDR_W'(ch * CH_STRIDE + ofs);
    endfunction
endpackage

// File: rtl/mtimer_glb.sv
module mtimer_glb import mtimer_pkg::*; #(
    parameter int unsigned NUM_TIMERS = 3,
    parameter int unsigned SEL_W      = 2,
    localparam int unsigned GW        = NUM_TIMERS * SEL_W
) (
    input  logic                                 clk_i,
    input  logic                                 rst_ni,
    input  logic                                 we_i,
    input  logic [ADDR_W-1:0]                    addr_i,
    input  logic [GW-1:0]                        wdata_i,
    output logic [NUM_TIMERS-1:0]                run_o,
    output logic [NUM_TIMERS-1:0]                per_o,
    output logic [NUM_TIMERS-1:0][SEL_W-1:0]     tsel_o,
    output logic [BUS_W-1:0]                     rdata_o
);
    typedef struct packed {
        logic [NUM_TIMERS-1:0]            run;
        logic [NUM_TIMERS-1:0]            per;
        logic [NUM_TIMERS-1:0][SEL_W-1:0] tsel;
    } glb_t;

    glb_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (we_i && addr_i == A_RUN)  s_d.run  = wdata_i[NUM_TIMERS-1:0];
        if (we_i && addr_i == A_MODE) s_d.per  = wdata_i[NUM_TIMERS-1:0];
        if (we_i && addr_i == A_TSEL) s_d.tsel = wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == A_RUN)       rdata_o = BUS_W'(s_q.run);
        else if (addr_i == A_MODE) rdata_o = BUS_W'(s_q.per);
        else if (addr_i == A_TSEL) rdata_o = BUS_W'(s_q.tsel);
    end

    assign run_o  = s_q.run;
    assign per_o  = s_q.per;
    assign tsel_o = s_q.tsel;
endmodule

// File: rtl/mtimer_chan.sv
module mtimer_chan import mtimer_pkg::*; #(
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned NUM_CMP = 3
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 run_i,
    input  logic                 periodic_i,
    input  logic                 tick_i,
    input  logic                 acc_i,
    input  logic                 we_i,
    input  logic [OFS_W-1:0]     ofs_i,
    input  logic [BUS_W-1:0]     wdata_i,
    output logic [CNT_W-1:0]     cnt_o,
    output logic [NUM_CMP-1:0]   stat_o,
    output logic [NUM_CMP-1:0]   ien_o,
    output logic [BUS_W-1:0]     rdata_o,
    output logic                 irq_o
);
    typedef struct packed {
        logic [CNT_W-1:0]              cnt;
        logic [NUM_CMP-1:0]            stat;
        logic [NUM_CMP-1:0]            ien;
        logic [NUM_CMP-1:0][CNT_W-1:0] match;
        logic [1:0]                    req;
        logic [CNT_W-1:0]              cap;
    } chan_t;

    chan_t              s_d, s_q;
    logic [NUM_CMP-1:0] hit;
    logic               wr;

    always_comb begin
        s_d = s_q;
        wr  = acc_i && we_i;
        for (int k = 0; k < NUM_CMP; k++) begin
            hit[k] = run_i && (s_q.cnt == s_q.match[k]);
        end
        // counting: periodic reload on match 0, else increment with wrap
        if (run_i && tick_i) begin
            s_d.cnt = (periodic_i && hit[0]) ? '0 : s_q.cnt + CNT_W'(1);
        end
        // sticky status: clear first, set afterwards so a set wins
        if (wr && ofs_i == OFS_STAT) s_d.stat = s_q.stat & ~wdata_i[NUM_CMP-1:0];
        s_d.stat = s_d.stat | hit;
        if (wr && ofs_i == OFS_IEN) s_d.ien = wdata_i[NUM_CMP-1:0];
        for (int k = 0; k < NUM_CMP; k++) begin
            if (wr && ofs_i == OFS_W'(int'(OFS_MATCH) + k)) s_d.match[k] = wdata_i[CNT_W-1:0];
        end
        // two-stage capture request, latch on the second edge
        s_d.req = {s_q.req[0], wr && ofs_i == OFS_CAP && wdata_i[0]};
        if (s_q.req[1]) s_d.cap = s_q.cnt;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    always_comb begin
        rdata_o = '0;
        if (ofs_i == OFS_STAT)     rdata_o[NUM_CMP-1:0] = s_q.stat;
        else if (ofs_i == OFS_IEN) rdata_o[NUM_CMP-1:0] = s_q.ien;
        else if (ofs_i == OFS_CAP) rdata_o[CNT_W-1:0]   = s_q.cap;
        else begin
            for (int k = 0; k < NUM_CMP; k++) begin
                if (ofs_i == OFS_W'(int'(OFS_MATCH) + k)) rdata_o[CNT_W-1:0] = s_q.match[k];
            end
        end
    end

    assign cnt_o  = s_q.cnt;
    assign stat_o = s_q.stat;
    assign ien_o  = s_q.ien;
    assign irq_o  = |(s_q.stat & s_q.ien);
endmodule

// File: rtl/mtimer_top.sv
module mtimer_top import mtimer_pkg::*; #(
    parameter int unsigned NUM_TIMERS = 3,
    parameter int unsigned NUM_CMP    = 3,
    parameter int unsigned CNT_W      = 32,
    parameter int unsigned NUM_TICK   = 4
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  bus_we_i,
    input  logic [ADDR_W-1:0]     bus_addr_i,
    input  logic [BUS_W-1:0]      bus_wdata_i,
    output logic [BUS_W-1:0]      bus_rdata_o,
    input  logic [NUM_TICK-1:0]   tick_i,
    output logic [NUM_TIMERS-1:0] irq_o
);
    localparam int unsigned SEL_W = (NUM_TICK > 1) ? $clog2(NUM_TICK) : 1;
    localparam int unsigned GW    = NUM_TIMERS * SEL_W;

    logic [NUM_TIMERS-1:0]              run_q, per_q, ch_acc, tick_ch;
    logic [NUM_TIMERS-1:0][SEL_W-1:0]   tsel_q;
    logic [BUS_W-1:0]                   glb_rdata;
    logic [NUM_TIMERS-1:0][BUS_W-1:0]   ch_rdata;
    logic [NUM_TIMERS-1:0][CNT_W-1:0]   cnt_all;
    logic [NUM_TIMERS-1:0][NUM_CMP-1:0] stat_all, ien_all;

    mtimer_glb #(.NUM_TIMERS(NUM_TIMERS), .SEL_W(SEL_W)) i_glb (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (bus_we_i),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i[GW-1:0]),
        .run_o   (run_q),
        .per_o   (per_q),
        .tsel_o  (tsel_q),
        .rdata_o (glb_rdata)
    );

    for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_ch
        localparam logic [ADDR_W-1:0] BASE = ch_addr(g, 0);
        assign ch_acc[g]  = bus_addr_i[ADDR_W-1:OFS_W] == BASE[ADDR_W-1:OFS_W];
        assign tick_ch[g] = (int'(tsel_q[g]) < NUM_TICK) ? tick_i[tsel_q[g]] : 1'b0;

        mtimer_chan #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) i_chan (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .run_i      (run_q[g]),
            .periodic_i (per_q[g]),
            .tick_i     (tick_ch[g]),
            .acc_i      (ch_acc[g]),
            .we_i       (bus_we_i),
            .ofs_i      (bus_addr_i[OFS_W-1:0]),
            .wdata_i    (bus_wdata_i),
            .cnt_o      (cnt_all[g]),
            .stat_o     (stat_all[g]),
            .ien_o      (ien_all[g]),
            .rdata_o    (ch_rdata[g]),
            .irq_o      (irq_o[g])
        );
    end

    always_comb begin
        bus_rdata_o = glb_rdata;
        for (int n = 0; n < NUM_TIMERS; n++) begin
            if (ch_acc[n]) bus_rdata_o = bus_rdata_o | ch_rdata[n];
        end
    end
endmodule

// File: rtl/mtimer_chk.sv
module mtimer_chk import mtimer_pkg::*; #(
    parameter int unsigned NT = 3,
    parameter int unsigned NC = 3,
    parameter int unsigned CW = 32
) (
    input logic                  clk_i,
    input logic                  rst_ni,
    input logic                  bus_we_i,
    input logic [ADDR_W-1:0]     bus_addr_i,
    input logic [NC-1:0]         wdata_lo,
    input logic [NT-1:0]         run_q,
    input logic [NT-1:0][CW-1:0] cnt_all,
    input logic [NT-1:0][NC-1:0] stat_all,
    input logic [NT-1:0][NC-1:0] ien_all,
    input logic [NT-1:0]         irq_o
);
    for (genvar n = 0; n < NT; n++) begin : g_t
        localparam logic [ADDR_W-1:0] A_ST = ch_addr(n, 0);

        p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !run_q[n] |=> cnt_all[n] == $past(cnt_all[n]));

        p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            run_q[n] |=> (cnt_all[n] == $past(cnt_all[n])) ||
                         (cnt_all[n] == CW'($past(cnt_all[n]) + 1'b1)) ||
                         (cnt_all[n] == '0));

        p_irq_mask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            irq_o[n] |-> (ien_all[n] != '0) && (stat_all[n] != '0));

        for (genvar k = 0; k < NC; k++) begin : g_c
            p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
                stat_all[n][k] && !(bus_we_i && bus_addr_i == A_ST && wdata_lo[k])
                |=> stat_all[n][k]);
        end
    end
endmodule

bind mtimer_top mtimer_chk #(.NT(NUM_TIMERS), .NC(NUM_CMP), .CW(CNT_W)) i_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_we_i   (bus_we_i),
    .bus_addr_i (bus_addr_i),
    .wdata_lo   (bus_wdata_i[NUM_CMP-1:0]),
    .run_q      (run_q),
    .cnt_all    (cnt_all),
    .stat_all   (stat_all),
    .ien_all    (ien_all),
    .irq_o      (irq_o)
);

// File: tb/test_mtimer_top.sv
module test_mtimer_top;
    localparam int NT = 3, NC = 3, CW = 8, NTK = 4, SW = 2;
    localparam time TCK = 20ns;

    logic          clk_i = 1'b0;
    logic          rst_ni = 1'b0;
    logic          we = 1'b0;
    logic [7:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NTK-1:0] tick = '0;
    logic [NT-1:0] irq;

    int  n_chk = 0, n_fail = 0;
    bit  done = 0, irq_on = 0;

    always #(TCK/2) clk_i = ~clk_i;

    mtimer_top #(.NUM_TIMERS(NT), .NUM_CMP(NC), .CNT_W(CW), .NUM_TICK(NTK)) i_mtimer_top (
        .clk_i(clk_i), .rst_ni(rst_ni), .bus_we_i(we), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .tick_i(tick), .irq_o(irq)
    );

    // reference model of the requirements
    logic [NT-1:0] m_run, m_per;
    logic [SW-1:0] m_sel [NT];
    logic [NC-1:0] m_st [NT];
    logic [NC-1:0] m_ie [NT];
    logic [CW-1:0] m_match [NT][NC];
    logic [CW-1:0] m_cnt [NT];
    logic [CW-1:0] m_cap [NT];
    logic [1:0]    m_req [NT];

    always @(posedge clk_i) begin
        logic [NC-1:0] hit;
        logic          wr, tk;
        logic [7:0]    base;
        if (!rst_ni) begin
            m_run = '0; m_per = '0;
            for (int n = 0; n < NT; n++) begin
                m_sel[n] = '0; m_st[n] = '0; m_ie[n] = '0; m_cnt[n] = '0;
                m_cap[n] = '0; m_req[n] = '0;
                for (int k = 0; k < NC; k++) m_match[n][k] = '0;
            end
        end else begin
            for (int n = 0; n < NT; n++) begin
                base = 8'(16 + 8 * n);
                tk   = tick[m_sel[n]];
                wr   = we && (addr[7:3] == base[7:3]);
                for (int k = 0; k < NC; k++) hit[k] = m_run[n] && (m_cnt[n] == m_match[n][k]);
                if (wr && addr[2:0] == 3'd0) m_st[n] = m_st[n] & ~wdata[NC-1:0];
                m_st[n] = m_st[n] | hit;
                if (wr && addr[2:0] == 3'd1) m_ie[n] = wdata[NC-1:0];
                if (m_req[n][1]) m_cap[n] = m_cnt[n];
                m_req[n] = {m_req[n][0], wr && addr[2:0] == 3'd2 && wdata[0]};
                if (m_run[n] && tk) m_cnt[n] = (m_per[n] && hit[0]) ? '0 : m_cnt[n] + 1'b1;
                for (int k = 0; k < NC; k++)
                    if (wr && addr[2:0] == 3'(4 + k)) m_match[n][k] = wdata[CW-1:0];
            end
            if (we && addr == 8'h00) m_run = wdata[NT-1:0];
            if (we && addr == 8'h01) m_per = wdata[NT-1:0];
            if (we && addr == 8'h02) for (int n = 0; n < NT; n++) m_sel[n] = wdata[2*n +: 2];
        end
    end

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        logic [31:0] r = '0;
        if (a == 8'h00) r = 32'(m_run);
        else if (a == 8'h01) r = 32'(m_per);
        else if (a == 8'h02) begin
            for (int n = 0; n < NT; n++) r[2*n +: 2] = m_sel[n];
        end else begin
            for (int n = 0; n < NT; n++) begin
                if (a[7:3] == 5'(2 + n)) begin
                    case (a[2:0])
                        3'd0: r = 32'(m_st[n]);
                        3'd1: r = 32'(m_ie[n]);
                        3'd2: r = 32'(m_cap[n]);
                        3'd4, 3'd5, 3'd6: r = 32'(m_match[n][int'(a[2:0]) - 4]);
                        default: r = '0;
                    endcase
                end
            end
        end
        return r;
    endfunction

    function automatic logic [NT-1:0] exp_irq();
        logic [NT-1:0] r;
        for (int n = 0; n < NT; n++) r[n] = |(m_st[n] & m_ie[n]);
        return r;
    endfunction

    function automatic string req_of(input logic [7:0] a);
        if (a == 8'h00) return "R2";
        if (a == 8'h01) return "R5";
        if (a == 8'h02) return "R3";
        if (a < 8'h10 || a >= 8'h28 || a[2:0] == 3'd3 || a[2:0] == 3'd7) return "R10";
        if (a[2:0] == 3'd0) return "R6";
        if (a[2:0] == 3'd1) return "R8";
        if (a[2:0] == 3'd2) return "R9";
        return "R6";
    endfunction

    function automatic logic [7:0] ch(input int n, input int ofs);
        return 8'(16 + 8 * n + ofs);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk_i); we = 1'b1; addr = a; wdata = d;
        @(negedge clk_i); we = 1'b0;
    endtask

    task automatic rd_exp(input logic [7:0] a, input logic [31:0] e, input string req);
        addr = a; we = 1'b0; #2;
        check(rdata === e, req, rdata, e);
    endtask

    task automatic run_ticks(input int idx, input int cnt);
        @(negedge clk_i); tick[idx] = 1'b1;
        repeat (cnt) @(negedge clk_i);
        tick[idx] = 1'b0;
    endtask

    task automatic cap_chk(input int n, input logic [31:0] e, input string req);
        wr(ch(n, 2), 32'd1);
        @(negedge clk_i); @(negedge clk_i);
        rd_exp(ch(n, 2), e, req);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // interrupt lines compared with the model every cycle
    always @(negedge clk_i) begin
        if (rst_ni && irq_on) begin
            #3;
            check(irq === exp_irq(), "R8", 32'(irq), 32'(exp_irq()));
        end
    end

    initial begin
        #(TCK * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [7:0] a;
        int op, r;
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);

        // R1: reset state
        for (int i = 0; i < 3; i++) rd_exp(8'(i), 32'd0, "R1");
        for (int n = 0; n < NT; n++)
            for (int o = 0; o < 7; o++) if (o != 3) rd_exp(ch(n, o), 32'd0, "R1");
        check(irq === '0, "R1", 32'(irq), 32'd0);
        irq_on = 1;

        // R3: timer 0 follows tick 1 only
        wr(8'h02, 32'h1);
        wr(8'h00, 32'h1);
        run_ticks(1, 5);
        run_ticks(0, 3);
        cap_chk(0, 32'd5, "R3");

        // R2: frozen while stopped, resumes afterwards
        wr(8'h00, 32'h0);
        run_ticks(1, 4);
        cap_chk(0, 32'd5, "R2");
        wr(8'h00, 32'h1);
        run_ticks(1, 2);

        // R9: latched value appears at the second edge after the request
        wr(ch(0, 2), 32'd1);
        rd_exp(ch(0, 2), 32'd5, "R9");
        @(negedge clk_i);
        rd_exp(ch(0, 2), 32'd5, "R9");
        @(negedge clk_i);
        rd_exp(ch(0, 2), 32'd7, "R9");

        // R4: free-running wrap on timer 1
        wr(8'h00, 32'h3);
        run_ticks(0, 260);
        cap_chk(1, 32'd4, "R4");
        rd_exp(ch(1, 0), 32'h7, "R6");

        // R5: periodic timer 2, match0 = 4 gives period 5
        wr(ch(2, 4), 32'd4);
        wr(ch(2, 5), 32'd9);
        wr(ch(2, 6), 32'd2);
        wr(8'h01, 32'h4);
        wr(8'h00, 32'h7);
        run_ticks(0, 13);
        cap_chk(2, 32'd3, "R5");
        rd_exp(ch(2, 0), 32'h5, "R6");

        // R7: write-one-to-clear and set-wins
        wr(ch(2, 0), 32'h1);
        rd_exp(ch(2, 0), 32'h4, "R7");
        wr(ch(2, 4), 32'd3);
        wr(ch(2, 0), 32'h1);
        rd_exp(ch(2, 0), 32'h5, "R7");

        // R8: enable mask
        wr(ch(2, 1), 32'h2);
        check(irq[2] === 1'b0, "R8", 32'(irq[2]), 32'd0);
        wr(ch(2, 1), 32'h4);
        check(irq[2] === 1'b1, "R8", 32'(irq[2]), 32'd1);

        // R10: unmapped write then read
        wr(8'h13, 32'hFFFF_FFFF);
        rd_exp(8'h13, 32'd0, "R10");
        rd_exp(ch(2, 4), 32'd3, "R10");

        // random phase against the model
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk_i);
            we = 1'b0;
            tick = 4'($urandom);
            r = $urandom_range(0, 15);
            case (r)
                0: a = 8'h00;
                1: a = 8'h01;
                2: a = 8'h02;
                3: a = ($urandom_range(0, 1) == 0) ? 8'h03 : 8'h28;
                default: begin
                    op = $urandom_range(0, 6);
                    a  = ch($urandom_range(0, NT - 1), (op < 3) ? op : op + 1);
                end
            endcase
            op = $urandom_range(0, 9);
            if (op < 4) begin
                we = 1'b1; addr = a; wdata = $urandom;
            end else begin
                rd_exp(a, exp_rd(a), req_of(a));
            end
        end
        @(negedge clk_i); we = 1'b0; tick = '0;
        @(negedge clk_i);
        done = 1;
        summary();
    end
endmodule